// File: doc/BRIEF.md
# System Bus Ownership Arbiter

This block decides which of two masters, a CPU and a DMA controller, owns a single shared system bus. Each master holds a request line and receives a grant. The grant moves only where the bus is at a legal break. The CPU reports the last clock of each bus cycle, whether that cycle is followed by more pieces of the same split access, and whether it is asleep. The DMA side reports its transfer mode and three completion strobes: one transfer done, one block done, and the whole job done.

The CPU is the default owner. When the DMA wins the bus it keeps it until the release point that its mode defines. The grant then comes straight back to the CPU, which is guaranteed a configurable number of completed bus cycles before the DMA can win again. A power-on reset clears everything at once. A manual reset freezes ownership. A CPU cycle caught by a manual reset is allowed to finish with its wait input masked and with its write data marked as unreliable.

Top module: `sysbus_arbiter`

## Requirements
- R1: After power-on reset, cpu_gnt_o=1, dma_gnt_o=0 and owner_o=0. owner_o is 0 when the CPU owns the bus and 1 when the DMA owns it. Exactly one grant is high at any time.
- R2: The grant moves from the CPU to the DMA only on the clock edge after a break. A break is one of: a clock where cpu_cyc_end_i=1 with cpu_multi_i=0; a clock with cpu_cyc_i=0 and cpu_req_i=0 outside a split access; a clock with cpu_sleep_i=1. A DMA request is never granted while a CPU cycle is still running.
- R3: A CPU cycle that ends with cpu_multi_i=1 starts a split access. From that point until a cycle ends with cpu_multi_i=0, the grant does not move, even if the CPU goes idle in between.
- R4: While cpu_sleep_i=1, a pending DMA request is granted on the next edge, whatever the CPU cycle signals show.
- R5: When the DMA request is eligible at a break, the DMA wins, and dma_gnt_o is high one edge after the break.
- R6: In single mode (dma_mode_i=2'b00, and also for the unused code 2'b11), the DMA gives up the bus on the edge after dma_xfer_end_i. The DMA also gives up the bus in any mode on the edge after dma_req_i drops.
- R7: In block mode (dma_mode_i=2'b01), the DMA keeps the bus across dma_xfer_end_i. It gives the bus up on the edge after dma_blk_end_i or dma_done_i.
- R8: In burst mode (dma_mode_i=2'b10), the DMA keeps the bus across dma_xfer_end_i and dma_blk_end_i. It gives the bus up only on the edge after dma_done_i.
- R9: After a DMA release, the CPU owns the bus at least until MIN_CPU_CYC CPU bus cycles have completed (default 1). This guard does not apply while the CPU is not requesting the bus or is asleep.
- R10: Driving rst_ni low returns the grants to the R1 state at once, without waiting for a clock edge.
- R11: While mrst_i=1, the grants do not change.
- R12: While a CPU cycle is in progress and either mrst_i=1 or a manual reset has already hit that cycle, wait_o=0 and wdata_ng_o=cpu_wr_i. This lasts until the clock in which cpu_cyc_end_i=1. At all other times wait_o=wait_i and wdata_ng_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| mrst_i | input | 1 | Manual reset, synchronous, active high |
| cpu_req_i | input | 1 | CPU wants to start a bus cycle |
| cpu_cyc_i | input | 1 | A CPU bus cycle is in progress |
| cpu_cyc_end_i | input | 1 | Last clock of the current CPU bus cycle |
| cpu_multi_i | input | 1 | The ending cycle is not the last piece of its access |
| cpu_wr_i | input | 1 | The current CPU cycle is a write |
| cpu_sleep_i | input | 1 | CPU is in sleep mode |
| wait_i | input | 1 | Wait request from the addressed target |
| dma_req_i | input | 1 | DMA bus request |
| dma_mode_i | input | 2 | DMA mode: 00 single, 01 block, 10 burst, 11 single |
| dma_xfer_end_i | input | 1 | One DMA transfer finished |
| dma_blk_end_i | input | 1 | One DMA block finished |
| dma_done_i | input | 1 | Whole DMA job finished |
| cpu_gnt_o | output | 1 | Bus granted to the CPU |
| dma_gnt_o | output | 1 | Bus granted to the DMA |
| owner_o | output | 1 | Current owner, 0 CPU, 1 DMA |
| wait_o | output | 1 | Wait passed to the bus master, masked during manual-reset completion |
| wdata_ng_o | output | 1 | Write data of the current cycle is not guaranteed |

## Verification
The assertions assume a well-behaved CPU: it raises cpu_cyc_i only while cpu_gnt_o is high, it never runs a bus cycle while asleep, and it pulses cpu_cyc_end_i only inside a cycle. They also assume the DMA holds dma_req_i for the whole of its ownership. The bench drives each scenario from a fresh reset on the falling clock edge, and its CPU cycles always begin while the CPU holds the grant. The manual-reset checks keep a cycle open across the mrst_i pulse, so the freeze and the masking are both seen while a cycle is in flight.

// File: rtl/sysbus_arb_pkg.sv
package sysbus_arb_pkg;
  typedef enum logic [0:0] {
    OWN_CPU = 1'b0,
    OWN_DMA = 1'b1
  } owner_e;

  typedef enum logic [1:0] {
    DMA_SINGLE = 2'b00,
    DMA_BLOCK  = 2'b01,
    DMA_BURST  = 2'b10,
    DMA_RSVD   = 2'b11
  } dma_mode_e;
endpackage

// File: rtl/cpu_break_det.sv
module cpu_break_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic cpu_req_i,
  input  logic cpu_cyc_i,
  input  logic cpu_cyc_end_i,
  input  logic cpu_multi_i,
  input  logic cpu_sleep_i,
  input  logic dma_gnt_i,
  output logic brk_o
);
  logic lock_q;

  // lock spans the gap between pieces of a split access
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       lock_q <= 1'b0;
    else if (!hold_i && cpu_cyc_end_i) lock_q <= cpu_multi_i;
  end

  always_comb begin
    brk_o = cpu_sleep_i
          | (cpu_cyc_end_i & ~cpu_multi_i)
          | (~cpu_cyc_i & ~cpu_req_i & ~lock_q);
  end

  AST_SPLIT_ATOMIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dma_gnt_i) |-> !$past(cpu_cyc_end_i && cpu_multi_i && !cpu_sleep_i)); // R3
endmodule

// File: rtl/dma_release.sv
module dma_release
  import sysbus_arb_pkg::*;
(
  input  logic       dma_req_i,
  input  logic [1:0] dma_mode_i,
  input  logic       dma_xfer_end_i,
  input  logic       dma_blk_end_i,
  input  logic       dma_done_i,
  output logic       rel_o
);
  logic mode_evt;

  always_comb begin
    unique case (dma_mode_e'(dma_mode_i))
      DMA_BLOCK: mode_evt = dma_blk_end_i;
      DMA_BURST: mode_evt = 1'b0;
      default:   mode_evt = dma_xfer_end_i;
    endcase
    rel_o = mode_evt | dma_done_i | ~dma_req_i;
  end
endmodule

// File: rtl/cpu_guard.sv
module cpu_guard #(
  parameter int unsigned MIN_CPU_CYC = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic arm_i,
  input  logic cpu_gnt_i,
  input  logic cpu_req_i,
  input  logic cpu_sleep_i,
  input  logic cpu_cyc_end_i,
  input  logic cpu_multi_i,
  output logic ok_o
);
  localparam int unsigned CW = (MIN_CPU_CYC < 1) ? 1 : $clog2(MIN_CPU_CYC + 1);

  logic cpu_done;
  assign cpu_done = cpu_cyc_end_i & ~cpu_multi_i;

  generate
    if (MIN_CPU_CYC == 0) begin : g_noguard
      assign ok_o = 1'b1;
    end else begin : g_guard
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else if (!hold_i) begin
          if (arm_i)                                  cnt_q <= CW'(MIN_CPU_CYC);
          else if (cnt_q != '0 && cpu_done && cpu_gnt_i) cnt_q <= cnt_q - 1'b1;
        end
      end
      assign ok_o = (cnt_q == '0) | ((cnt_q == CW'(1)) & cpu_done)
                  | ~cpu_req_i | cpu_sleep_i;

      AST_GUARD_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= CW'(MIN_CPU_CYC)); // R9
    end
  endgenerate
endmodule

// File: rtl/mrst_ctrl.sv
module mrst_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mrst_i,
  input  logic cpu_cyc_i,
  input  logic cpu_cyc_end_i,
  input  logic cpu_wr_i,
  input  logic wait_i,
  output logic wait_o,
  output logic wdata_ng_o
);
  logic hit_q, cmpl;

  // remembers that the open cycle was caught by a manual reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               hit_q <= 1'b0;
    else if (cpu_cyc_end_i || !cpu_cyc_i)      hit_q <= 1'b0;
    else if (mrst_i)                           hit_q <= 1'b1;
  end

  assign cmpl       = cpu_cyc_i & (mrst_i | hit_q);
  assign wait_o     = wait_i & ~cmpl;
  assign wdata_ng_o = cmpl & cpu_wr_i;

  AST_MRST_NO_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mrst_i && cpu_cyc_i) |-> (!wait_o && (wdata_ng_o == cpu_wr_i))); // R12
  AST_MRST_TAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mrst_i && cpu_cyc_i && !cpu_cyc_end_i) && cpu_cyc_i) |-> !wait_o); // R12
endmodule

// File: rtl/sysbus_arbiter.sv
module sysbus_arbiter
  import sysbus_arb_pkg::*;
#(
  parameter int unsigned MIN_CPU_CYC = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mrst_i,
  input  logic       cpu_req_i,
  input  logic       cpu_cyc_i,
  input  logic       cpu_cyc_end_i,
  input  logic       cpu_multi_i,
  input  logic       cpu_wr_i,
  input  logic       cpu_sleep_i,
  input  logic       wait_i,
  input  logic       dma_req_i,
  input  logic [1:0] dma_mode_i,
  input  logic       dma_xfer_end_i,
  input  logic       dma_blk_end_i,
  input  logic       dma_done_i,
  output logic       cpu_gnt_o,
  output logic       dma_gnt_o,
  output logic       owner_o,
  output logic       wait_o,
  output logic       wdata_ng_o
);
  owner_e owner_q, owner_d;
  logic   brk, rel, guard_ok, arm;

  cpu_break_det u_brk (
    .clk_i, .rst_ni, .hold_i(mrst_i), .cpu_req_i, .cpu_cyc_i, .cpu_cyc_end_i,
    .cpu_multi_i, .cpu_sleep_i, .dma_gnt_i(dma_gnt_o), .brk_o(brk)
  );

  dma_release u_rel (
    .dma_req_i, .dma_mode_i, .dma_xfer_end_i, .dma_blk_end_i, .dma_done_i,
    .rel_o(rel)
  );

  cpu_guard #(.MIN_CPU_CYC(MIN_CPU_CYC)) u_guard (
    .clk_i, .rst_ni, .hold_i(mrst_i), .arm_i(arm), .cpu_gnt_i(cpu_gnt_o),
    .cpu_req_i, .cpu_sleep_i, .cpu_cyc_end_i, .cpu_multi_i, .ok_o(guard_ok)
  );

  mrst_ctrl u_mrst (
    .clk_i, .rst_ni, .mrst_i, .cpu_cyc_i, .cpu_cyc_end_i, .cpu_wr_i, .wait_i,
    .wait_o, .wdata_ng_o
  );

  assign arm = (owner_q == OWN_DMA) & rel & ~mrst_i;

  always_comb begin
    owner_d = owner_q;
    if (!mrst_i) begin
      unique case (owner_q)
        OWN_CPU: if (dma_req_i && brk && guard_ok) owner_d = OWN_DMA;
        OWN_DMA: if (rel)                          owner_d = OWN_CPU;
        default:                                   owner_d = OWN_CPU;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) owner_q <= OWN_CPU;
    else         owner_q <= owner_d;
  end

  assign cpu_gnt_o = (owner_q == OWN_CPU);
  assign dma_gnt_o = (owner_q == OWN_DMA);
  assign owner_o   = owner_q;

  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot({cpu_gnt_o, dma_gnt_o}) && (owner_o == dma_gnt_o)); // R1
  AST_GNT_AT_BREAK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dma_gnt_o) |-> $past(cpu_sleep_i || (cpu_cyc_end_i && !cpu_multi_i)
                               || (!cpu_cyc_i && !cpu_req_i))); // R2
  AST_SLEEP_YIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_gnt_o && cpu_sleep_i && dma_req_i && guard_ok && !mrst_i) |=> dma_gnt_o); // R4
  AST_DMA_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_gnt_o && brk && dma_req_i && guard_ok && !mrst_i) |=> dma_gnt_o); // R5
  AST_SINGLE_REL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_gnt_o && dma_xfer_end_i && !dma_mode_i[0] && !dma_mode_i[1] && !mrst_i)
      |=> cpu_gnt_o); // R6
  AST_BLOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_gnt_o && dma_mode_i == 2'b01 && dma_req_i && !dma_blk_end_i && !dma_done_i)
      |=> dma_gnt_o); // R7
  AST_BURST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_gnt_o && dma_mode_i == 2'b10 && dma_req_i && !dma_done_i) |=> dma_gnt_o); // R8
  AST_CPU_TURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(dma_gnt_o) && cpu_req_i && !cpu_sleep_i && !cpu_cyc_end_i && !mrst_i)
      |=> !dma_gnt_o); // R9
  AST_MRST_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrst_i |=> $stable(dma_gnt_o)); // R11
endmodule

// File: tb/sysbus_arbiter_tb_top.sv
module sysbus_arbiter_tb_top;
  logic clk = 1'b0, rst_ni = 1'b0, mrst = 1'b0;
  logic cpu_req = 0, cpu_cyc = 0, cpu_end = 0, cpu_multi = 0, cpu_wr = 0, cpu_sleep = 0;
  logic wait_in = 0, dma_req = 0, x_end = 0, b_end = 0, d_done = 0;
  logic [1:0] dma_mode = 2'b00;
  logic cpu_gnt, dma_gnt, owner, wait_out, wdata_ng;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  sysbus_arbiter dut_i (
    .clk_i(clk), .rst_ni, .mrst_i(mrst), .cpu_req_i(cpu_req), .cpu_cyc_i(cpu_cyc),
    .cpu_cyc_end_i(cpu_end), .cpu_multi_i(cpu_multi), .cpu_wr_i(cpu_wr),
    .cpu_sleep_i(cpu_sleep), .wait_i(wait_in), .dma_req_i(dma_req),
    .dma_mode_i(dma_mode), .dma_xfer_end_i(x_end), .dma_blk_end_i(b_end),
    .dma_done_i(d_done), .cpu_gnt_o(cpu_gnt), .dma_gnt_o(dma_gnt), .owner_o(owner),
    .wait_o(wait_out), .wdata_ng_o(wdata_ng)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic quiet();
    mrst = 0; cpu_req = 0; cpu_cyc = 0; cpu_end = 0; cpu_multi = 0; cpu_wr = 0;
    cpu_sleep = 0; wait_in = 0; dma_req = 0; x_end = 0; b_end = 0; d_done = 0;
    dma_mode = 2'b00;
  endtask

  task automatic do_reset();
    quiet();
    rst_ni = 0; step(); step(); rst_ni = 1; step();
  endtask

  // DMA takes the bus from an idle CPU
  task automatic grab_idle();
    dma_req = 1; step();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 cpu_gnt", cpu_gnt, 1); chk("R1 dma_gnt", dma_gnt, 0); chk("R1 owner", owner, 0);
  endtask

  task automatic t_break_and_guard();
    do_reset();
    cpu_req = 1; cpu_cyc = 1; dma_req = 1;
    step(); step();
    chk("R2 mid-cycle hold", dma_gnt, 0);
    cpu_end = 1; step(); cpu_end = 0; cpu_req = 1; cpu_cyc = 0;
    chk("R5 dma wins at break", dma_gnt, 1); chk("R1 owner dma", owner, 1);
    dma_mode = 2'b00; x_end = 1; step(); x_end = 0;
    chk("R6 single release", cpu_gnt, 1);
    cpu_cyc = 1; step(); step();
    chk("R9 cpu keeps bus", cpu_gnt, 1);
    cpu_end = 1; step(); cpu_end = 0; cpu_cyc = 0;
    chk("R9 dma after cpu cycle", dma_gnt, 1);
  endtask

  task automatic t_split();
    do_reset();
    cpu_req = 1; cpu_cyc = 1; dma_req = 1;
    cpu_end = 1; cpu_multi = 1; step();
    chk("R3 no grant between pieces", dma_gnt, 0);
    cpu_end = 0; cpu_multi = 0; cpu_cyc = 0; cpu_req = 0; step();
    chk("R3 idle gap locked", dma_gnt, 0);
    cpu_req = 1; cpu_cyc = 1; step();
    cpu_end = 1; step(); cpu_end = 0; cpu_cyc = 0;
    chk("R3 grant after last piece", dma_gnt, 1);
  endtask

  task automatic t_sleep();
    do_reset();
    cpu_req = 1; cpu_cyc = 1; step();
    cpu_sleep = 1; cpu_cyc = 0; dma_req = 1; step();
    chk("R4 sleep yields", dma_gnt, 1);
  endtask

  task automatic t_block();
    do_reset();
    dma_mode = 2'b01; grab_idle();
    x_end = 1; step(); x_end = 0;
    chk("R7 block holds over transfer", dma_gnt, 1);
    b_end = 1; step(); b_end = 0;
    chk("R7 block releases", cpu_gnt, 1);
  endtask

  task automatic t_burst();
    do_reset();
    dma_mode = 2'b10; grab_idle();
    x_end = 1; b_end = 1; step(); x_end = 0; b_end = 0;
    chk("R8 burst holds", dma_gnt, 1);
    d_done = 1; step(); d_done = 0;
    chk("R8 burst releases", cpu_gnt, 1);
  endtask

  task automatic t_withdraw();
    do_reset();
    dma_mode = 2'b10; grab_idle();
    dma_req = 0; step();
    chk("R6 withdraw release", cpu_gnt, 1);
  endtask

  task automatic t_mrst();
    do_reset();
    cpu_req = 1; cpu_cyc = 1; wait_in = 1; cpu_wr = 1; #1;
    chk("R12 wait passes", wait_out, 1); chk("R12 wdata ok", wdata_ng, 0);
    step();
    mrst = 1; dma_req = 1; #1;
    chk("R12 wait masked", wait_out, 0); chk("R12 wdata flagged", wdata_ng, 1);
    step(); mrst = 0; #1;
    chk("R12 mask held after pulse", wait_out, 0);
    cpu_end = 1; step(); cpu_end = 0; cpu_cyc = 0; cpu_req = 1; #1;
    chk("R12 mask cleared", wait_out, 1);
    chk("R5 grant after manual reset", dma_gnt, 1);
    // freeze: break under manual reset moves nothing
    x_end = 1; mrst = 1; step(); x_end = 0;
    chk("R11 frozen", dma_gnt, 1);
    mrst = 0; x_end = 1; step(); x_end = 0;
    chk("R11 released after", cpu_gnt, 1);
  endtask

  task automatic t_por();
    do_reset();
    dma_mode = 2'b10; grab_idle();
    chk("R10 dma owned", dma_gnt, 1);
    #1 rst_ni = 0; #1;
    chk("R10 async cpu_gnt", cpu_gnt, 1); chk("R10 async dma_gnt", dma_gnt, 0);
    step(); rst_ni = 1; step();
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset(); t_break_and_guard(); t_split(); t_sleep(); t_block();
    t_burst(); t_withdraw(); t_mrst(); t_por();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule